// File: doc/BRIEF.md
# Load-Use and Branch Stall Counter

This block is a performance-monitoring tally for an in-order pipeline. Every issued instruction is presented once on the issue port, together with:

- its unit class;
- up to two source register numbers, each with its own valid bit;
- a destination register number;
- a taken flag that matters only for control transfers.

The block never stalls anything. It only accumulates the penalty cycles that a simple timing model would charge.

A load marks its destination register as in flight for exactly one following instruction. When that following instruction reads the marked register as a checked source operand, the load-stall tally grows by a fixed penalty of two for each such operand. A taken control transfer charges a two-cycle penalty to the branch-stall tally. Separate tallies record how many control transfers were taken and how many were not.

The shadow of a load is tracked by a two-state machine:

- **ST_CLEAN**: no register is marked. The transition *mark* leads to ST_SHADOW when a load issues.
- **ST_SHADOW**: exactly one register is marked. The transition *remark* stays in ST_SHADOW when another load issues. The transition *retire* returns to ST_CLEAN when any other instruction issues.
- The transition *flush* returns to ST_CLEAN from either state on a synchronous clear.
- Cycles without an issue leave the state and the mark untouched, because the mark ages per instruction, not per cycle.

All four tallies saturate at their maximum value.

Top module: `stall_tally`

## Requirements
- R1: A load (unit code 4) that issues marks its destination register. That mark is visible to the next issued instruction only. Cycles with `issue` low neither age nor remove the mark. Any following issued instruction replaces the mark with its own: the mark of a load, or no mark at all.
- R2: Execute, compare and multiply-accumulate instructions (unit codes 0, 1 and 2) check both source operands against the mark. Each operand that hits adds 2 to `load_stall_cnt`, so two operands that name the same marked register add 4.
- R3: A source operand whose valid bit is 0 never causes a stall, whatever its register number.
- R4: A control transfer (unit code 3) checks only source A for a load stall. Source B is ignored.
- R5: A taken control transfer adds 2 to `branch_stall_cnt` and 1 to `taken_cnt`. An untaken control transfer adds 1 to `untaken_cnt`. `br_taken` has no effect on any other unit code.
- R6: Loads, stores (unit code 5) and the reserved codes 6 and 7 check no operand and change no tally. Stores and the reserved codes still remove any mark.
- R7: Tallies change on the same rising edge that samples `issue` high, and are visible in the following cycle.
- R8: Over long mixed instruction streams, all four tallies match a reference model of R1 to R7.
- R9: Every tally of width `CNT_W` stops at 2^`CNT_W`-1 and never wraps.
- R10: `clear` high at a rising edge zeroes all tallies and removes the mark. It takes priority over an issue in the same cycle.
- R11: After `rst_n` is released, all tallies read zero and no register is marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of tallies and mark |
| issue | input | 1 | An instruction issues this cycle |
| unit_kind | input | 3 | Unit class: 0 execute, 1 compare, 2 multiply-accumulate, 3 control transfer, 4 load, 5 store, 6 and 7 reserved |
| src_a_vld | input | 1 | Source A present |
| src_a_idx | input | IDX_W (4) | Source A register number |
| src_b_vld | input | 1 | Source B present |
| src_b_idx | input | IDX_W (4) | Source B register number |
| dst_idx | input | IDX_W (4) | Destination register number |
| br_taken | input | 1 | Control transfer taken |
| load_stall_cnt | output | CNT_W (32) | Load-stall cycles |
| branch_stall_cnt | output | CNT_W (32) | Branch-stall cycles |
| taken_cnt | output | CNT_W (32) | Taken control transfers |
| untaken_cnt | output | CNT_W (32) | Untaken control transfers |

## Verification
The hardest situation to reach from the ports is saturation. With 32-bit tallies it would take billions of instructions. The bench therefore drives a second instance with 6-bit tallies from the same stream, so that every tally climbs to its ceiling and then sits there under continued random traffic.

Hits in the load shadow are also rare when register numbers are drawn uniformly. The random stream therefore draws register numbers from a small pool and lets idle cycles fall between instructions, which keeps the mark surviving gaps in issue. Directed cases cover the rest:

- a doubled operand that hits twice;
- an invalid operand that carries a matching number;
- a control transfer whose source B matches the mark;
- a clear that coincides with a load.

// File: rtl/stall_pkg.sv
`timescale 1ns/1ps
package stall_pkg;

    // Unit class carried with each issued instruction.
    typedef enum logic [2:0] {
        UK_EXEC  = 3'd0,
        UK_CMP   = 3'd1,
        UK_MAC   = 3'd2,
        UK_CTI   = 3'd3,
        UK_LOAD  = 3'd4,
        UK_STORE = 3'd5,
        UK_RSV6  = 3'd6,
        UK_RSV7  = 3'd7
    } unit_kind_e;

    // Load-shadow tracker states.
    typedef enum logic {
        ST_CLEAN  = 1'b0,
        ST_SHADOW = 1'b1
    } shadow_st_e;

    // Per-instruction events produced by the operand checker.
    typedef struct packed {
        logic hit_a;
        logic hit_b;
        logic br_taken;
        logic br_untaken;
    } issue_evt_t;

endpackage

// File: rtl/hazard_track.sv
`timescale 1ns/1ps
// Tracks which register, if any, the previous issued instruction loaded.
module hazard_track
    import stall_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             issue,
    input  logic             is_load,
    input  logic [IDX_W-1:0] dst_idx,
    output logic [NREG-1:0]  loaded_mask,
    output shadow_st_e       state
);

    shadow_st_e      st_nxt;
    logic [NREG-1:0] pending_mask;

    // Mask formed by the instruction issuing this cycle; it is handed to
    // the loaded mask at the instruction boundary and never kept beyond.
    always_comb begin
        pending_mask = '0;
        if (is_load) begin
            pending_mask[dst_idx] = 1'b1;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLEAN;
        end else if (clear) begin
            state <= ST_CLEAN;              // flush
        end else begin
            state <= st_nxt;
        end
    end

    // Transitions.
    always_comb begin
        st_nxt = state;
        unique case (state)
            ST_CLEAN: begin
                if (issue && is_load) begin
                    st_nxt = ST_SHADOW;     // mark
                end
            end
            ST_SHADOW: begin
                if (issue && !is_load) begin
                    st_nxt = ST_CLEAN;      // retire
                end else if (issue) begin
                    st_nxt = ST_SHADOW;     // remark
                end
            end
            default: st_nxt = ST_CLEAN;
        endcase
    end

    // Output register: the loaded mask.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded_mask <= '0;
        end else if (clear) begin
            loaded_mask <= '0;
        end else if (issue) begin
            loaded_mask <= pending_mask;
        end
    end

endmodule

// File: rtl/operand_check.sv
`timescale 1ns/1ps
// Decides, per unit class, which operands are checked and which branch
// event (if any) the issuing instruction produces.
module operand_check
    import stall_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             issue,
    input  logic [2:0]       unit_kind,
    input  logic             src_a_vld,
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic             src_b_vld,
    input  logic [IDX_W-1:0] src_b_idx,
    input  logic             br_taken,
    input  logic [NREG-1:0]  loaded_mask,
    output issue_evt_t       evt
);

    unit_kind_e kind;
    logic       chk_a;
    logic       chk_b;
    logic       is_cti;
    logic       a_marked;
    logic       b_marked;

    assign kind     = unit_kind_e'(unit_kind);
    assign a_marked = src_a_vld && loaded_mask[src_a_idx];
    assign b_marked = src_b_vld && loaded_mask[src_b_idx];

    always_comb begin
        chk_a  = 1'b0;
        chk_b  = 1'b0;
        is_cti = 1'b0;
        unique case (kind)
            UK_EXEC, UK_CMP, UK_MAC: begin
                chk_a = 1'b1;
                chk_b = 1'b1;
            end
            UK_CTI: begin
                chk_a  = 1'b1;
                is_cti = 1'b1;
            end
            UK_LOAD, UK_STORE, UK_RSV6, UK_RSV7: begin
                chk_a = 1'b0;
            end
            default: chk_a = 1'b0;
        endcase
    end

    always_comb begin
        evt.hit_a      = issue && chk_a && a_marked;
        evt.hit_b      = issue && chk_b && b_marked;
        evt.br_taken   = issue && is_cti && br_taken;
        evt.br_untaken = issue && is_cti && !br_taken;
    end

endmodule

// File: rtl/sat_counter.sv
`timescale 1ns/1ps
// Saturating up-counter with a variable step.
module sat_counter #(
    parameter int W      = 32,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              inc_en,
    input  logic [STEP_W-1:0] step,
    output logic [W-1:0]      cnt
);

    localparam int SUM_W = (W > STEP_W) ? W + 1 : STEP_W + 1;

    logic [SUM_W-1:0] sum;
    logic             over;

    assign sum  = SUM_W'(cnt) + SUM_W'(step);
    assign over = |sum[SUM_W-1:W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (inc_en) begin
            cnt <= over ? '1 : sum[W-1:0];
        end
    end

endmodule

// File: rtl/stall_tally.sv
`timescale 1ns/1ps
// Load-use and branch stall counter: top level.
module stall_tally
    import stall_pkg::*;
#(
    parameter int NREG      = 16,
    parameter int CNT_W     = 32,
    parameter int STALL_PEN = 2,
    parameter int IDX_W     = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             issue,
    input  logic [2:0]       unit_kind,
    input  logic             src_a_vld,
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic             src_b_vld,
    input  logic [IDX_W-1:0] src_b_idx,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             br_taken,
    output logic [CNT_W-1:0] load_stall_cnt,
    output logic [CNT_W-1:0] branch_stall_cnt,
    output logic [CNT_W-1:0] taken_cnt,
    output logic [CNT_W-1:0] untaken_cnt
);

    localparam int NCNT   = 4;
    localparam int STEP_W = $clog2(2 * STALL_PEN + 1);

    localparam int C_LOAD  = 0;
    localparam int C_BRST  = 1;
    localparam int C_TAKEN = 2;
    localparam int C_UNTKN = 3;

    logic [NREG-1:0]   loaded_mask;
    shadow_st_e        hz_state;
    issue_evt_t        evt;
    logic              is_load;

    logic [STEP_W-1:0] step_v [NCNT];
    logic              en_v   [NCNT];
    logic [CNT_W-1:0]  cnt_v  [NCNT];

    assign is_load = (unit_kind_e'(unit_kind) == UK_LOAD);

    hazard_track #(.NREG(NREG), .IDX_W(IDX_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .issue       (issue),
        .is_load     (is_load),
        .dst_idx     (dst_idx),
        .loaded_mask (loaded_mask),
        .state       (hz_state)
    );

    operand_check #(.NREG(NREG), .IDX_W(IDX_W)) u_check (
        .issue       (issue),
        .unit_kind   (unit_kind),
        .src_a_vld   (src_a_vld),
        .src_a_idx   (src_a_idx),
        .src_b_vld   (src_b_vld),
        .src_b_idx   (src_b_idx),
        .br_taken    (br_taken),
        .loaded_mask (loaded_mask),
        .evt         (evt)
    );

    // Step and enable per tally.
    always_comb begin
        step_v[C_LOAD]  = STEP_W'(evt.hit_a) * STEP_W'(STALL_PEN)
                        + STEP_W'(evt.hit_b) * STEP_W'(STALL_PEN);
        en_v[C_LOAD]    = evt.hit_a || evt.hit_b;
        step_v[C_BRST]  = STEP_W'(STALL_PEN);
        en_v[C_BRST]    = evt.br_taken;
        step_v[C_TAKEN] = STEP_W'(1);
        en_v[C_TAKEN]   = evt.br_taken;
        step_v[C_UNTKN] = STEP_W'(1);
        en_v[C_UNTKN]   = evt.br_untaken;
    end

    for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
        sat_counter #(.W(CNT_W), .STEP_W(STEP_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (clear),
            .inc_en (en_v[gi]),
            .step   (step_v[gi]),
            .cnt    (cnt_v[gi])
        );
    end

    assign load_stall_cnt   = cnt_v[C_LOAD];
    assign branch_stall_cnt = cnt_v[C_BRST];
    assign taken_cnt        = cnt_v[C_TAKEN];
    assign untaken_cnt      = cnt_v[C_UNTKN];

endmodule

// File: rtl/stall_tally_chk.sv
`timescale 1ns/1ps
module stall_tally_chk
    import stall_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int CNT_W = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             issue,
    input logic [2:0]       unit_kind,
    input logic [IDX_W-1:0] dst_idx,
    input logic [NREG-1:0]  loaded_mask,
    input shadow_st_e       hz_state,
    input logic [CNT_W-1:0] load_stall_cnt,
    input logic [CNT_W-1:0] branch_stall_cnt,
    input logic [CNT_W-1:0] taken_cnt,
    input logic [CNT_W-1:0] untaken_cnt
);

    AST_LOAD_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !clear && unit_kind == 3'd4)
        |=> ($countones(loaded_mask) == 1 && loaded_mask[$past(dst_idx)])); // R1

    AST_SHADOW_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !clear && unit_kind != 3'd4) |=> (loaded_mask == '0)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue && !clear) |=> $stable(loaded_mask)); // R1

    AST_STATE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        ((hz_state == ST_SHADOW) == (loaded_mask != '0))); // R1

    AST_STORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !clear && unit_kind >= 3'd4)
        |=> ($stable(load_stall_cnt) && $stable(branch_stall_cnt)
             && $stable(taken_cnt) && $stable(untaken_cnt))); // R6

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (load_stall_cnt >= $past(load_stall_cnt)
                    && branch_stall_cnt >= $past(branch_stall_cnt))); // R9

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (load_stall_cnt == '0 && branch_stall_cnt == '0
                   && taken_cnt == '0 && untaken_cnt == '0
                   && loaded_mask == '0)); // R10

    AST_IDLE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue && !clear) |=> ($stable(load_stall_cnt) && $stable(taken_cnt)
                                && $stable(untaken_cnt))); // R7

endmodule

bind stall_tally stall_tally_chk #(.NREG(NREG), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .clear            (clear),
    .issue            (issue),
    .unit_kind        (unit_kind),
    .dst_idx          (dst_idx),
    .loaded_mask      (loaded_mask),
    .hz_state         (hz_state),
    .load_stall_cnt   (load_stall_cnt),
    .branch_stall_cnt (branch_stall_cnt),
    .taken_cnt        (taken_cnt),
    .untaken_cnt      (untaken_cnt)
);

// File: tb/tb_stall_tally.sv
`timescale 1ns/1ps
module tb_stall_tally;

    localparam int NREG  = 16;
    localparam int IDX_W = 4;
    localparam int SAT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clear = 1'b0;
    logic             issue = 1'b0;
    logic [2:0]       unit_kind = '0;
    logic             src_a_vld = 1'b0;
    logic [IDX_W-1:0] src_a_idx = '0;
    logic             src_b_vld = 1'b0;
    logic [IDX_W-1:0] src_b_idx = '0;
    logic [IDX_W-1:0] dst_idx = '0;
    logic             br_taken = 1'b0;

    logic [31:0]      o_ld, o_bs, o_tk, o_ut;
    logic [SAT_W-1:0] s_ld, s_bs, s_tk, s_ut;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference model state.
    logic [NREG-1:0] m_mask = '0;
    longint          m_cnt [4];
    longint          s_cnt [4];

    always #2 clk = ~clk;

    stall_tally dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .issue(issue),
        .unit_kind(unit_kind), .src_a_vld(src_a_vld), .src_a_idx(src_a_idx),
        .src_b_vld(src_b_vld), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
        .br_taken(br_taken), .load_stall_cnt(o_ld), .branch_stall_cnt(o_bs),
        .taken_cnt(o_tk), .untaken_cnt(o_ut)
    );

    stall_tally #(.CNT_W(SAT_W)) dut_sat (
        .clk(clk), .rst_n(rst_n), .clear(clear), .issue(issue),
        .unit_kind(unit_kind), .src_a_vld(src_a_vld), .src_a_idx(src_a_idx),
        .src_b_vld(src_b_vld), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
        .br_taken(br_taken), .load_stall_cnt(s_ld), .branch_stall_cnt(s_bs),
        .taken_cnt(s_tk), .untaken_cnt(s_ut)
    );

    function automatic longint sat_add(longint cur, longint inc, longint maxv);
        return (cur + inc > maxv) ? maxv : cur + inc;
    endfunction

    task automatic chk(string tag, string what, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Advance the model by one clock edge using the current inputs.
    task automatic model_step();
        longint inc [4];
        int     hits = 0;
        for (int k = 0; k < 4; k++) inc[k] = 0;
        if (clear) begin
            m_mask = '0;
            for (int k = 0; k < 4; k++) begin
                m_cnt[k] = 0;
                s_cnt[k] = 0;
            end
        end else if (issue) begin
            if (unit_kind <= 3'd2) begin
                hits = int'(src_a_vld && m_mask[src_a_idx])
                     + int'(src_b_vld && m_mask[src_b_idx]);
            end else if (unit_kind == 3'd3) begin
                hits = int'(src_a_vld && m_mask[src_a_idx]);
                if (br_taken) begin
                    inc[1] = 2;
                    inc[2] = 1;
                end else begin
                    inc[3] = 1;
                end
            end
            inc[0] = 2 * hits;
            m_mask = '0;
            if (unit_kind == 3'd4) m_mask[dst_idx] = 1'b1;
            for (int k = 0; k < 4; k++) begin
                m_cnt[k] = sat_add(m_cnt[k], inc[k], 64'hFFFF_FFFF);
                s_cnt[k] = sat_add(s_cnt[k], inc[k], (64'd1 << SAT_W) - 1);
            end
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "load_stall",   longint'(o_ld), m_cnt[0]);
        chk(tag, "branch_stall", longint'(o_bs), m_cnt[1]);
        chk(tag, "taken",        longint'(o_tk), m_cnt[2]);
        chk(tag, "untaken",      longint'(o_ut), m_cnt[3]);
        chk("R9", "sat load_stall",   longint'(s_ld), s_cnt[0]);
        chk("R9", "sat branch_stall", longint'(s_bs), s_cnt[1]);
        chk("R9", "sat taken",        longint'(s_tk), s_cnt[2]);
        chk("R9", "sat untaken",      longint'(s_ut), s_cnt[3]);
    endtask

    // Drive one cycle (inputs set 1 ns after an edge), then check.
    task automatic cyc(string tag, bit iss, int kind, bit av, int ai,
                       bit bv, int bi, int di, bit tk, bit clr);
        issue     = iss;
        unit_kind = 3'(kind);
        src_a_vld = av;
        src_a_idx = IDX_W'(ai);
        src_b_vld = bv;
        src_b_idx = IDX_W'(bi);
        dst_idx   = IDX_W'(di);
        br_taken  = tk;
        clear     = clr;
        @(posedge clk);
        model_step();
        #1;
        compare_all(tag);
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            m_cnt[k] = 0;
            s_cnt[k] = 0;
        end
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1;
        compare_all("R11");

        // R1 / R2: load r5, then both operands read r5 -> +4.
        cyc("R1", 1, 4, 0, 0, 0, 0, 5, 0, 0);
        cyc("R2", 1, 0, 1, 5, 1, 5, 1, 0, 0);
        chk("R2", "double hit", longint'(o_ld), 4);

        // R1: mark survives idle cycles, compare hits once -> 6.
        cyc("R1", 1, 4, 0, 0, 0, 0, 7, 0, 0);
        idle("R1"); idle("R1"); idle("R1");
        cyc("R1", 1, 1, 1, 7, 0, 0, 0, 0, 0);
        chk("R1", "after gap", longint'(o_ld), 6);

        // R1: an intervening instruction ends the shadow.
        cyc("R1", 1, 4, 0, 0, 0, 0, 7, 0, 0);
        cyc("R1", 1, 0, 1, 1, 1, 2, 3, 0, 0);
        cyc("R1", 1, 2, 1, 7, 1, 7, 0, 0, 0);
        chk("R1", "shadow ended", longint'(o_ld), 6);

        // R3: invalid operands carrying the marked number.
        cyc("R3", 1, 4, 0, 0, 0, 0, 9, 0, 0);
        cyc("R3", 1, 0, 0, 9, 0, 9, 0, 0, 0);
        chk("R3", "invalid src", longint'(o_ld), 6);

        // R4: control transfer, source B matches -> no load stall.
        cyc("R4", 1, 4, 0, 0, 0, 0, 3, 0, 0);
        cyc("R4", 1, 3, 1, 0, 1, 3, 0, 1, 0);
        chk("R4", "src b ignored", longint'(o_ld), 6);
        chk("R5", "taken branch stall", longint'(o_bs), 2);
        cyc("R4", 1, 4, 0, 0, 0, 0, 3, 0, 0);
        cyc("R4", 1, 3, 1, 3, 0, 0, 0, 0, 0);
        chk("R4", "src a checked", longint'(o_ld), 8);
        chk("R5", "untaken", longint'(o_ut), 1);

        // R5: taken flag on a non-transfer has no effect.
        cyc("R5", 1, 0, 0, 0, 0, 0, 0, 1, 0);
        chk("R5", "taken on exec", longint'(o_tk), 1);

        // R6: store, load and reserved codes do not check operands.
        cyc("R6", 1, 4, 0, 0, 0, 0, 4, 0, 0);
        cyc("R6", 1, 5, 1, 4, 1, 4, 0, 1, 0);
        cyc("R6", 1, 4, 0, 0, 0, 0, 4, 0, 0);
        cyc("R6", 1, 4, 1, 4, 1, 4, 4, 0, 0);
        cyc("R6", 1, 6, 1, 4, 1, 4, 0, 1, 0);
        cyc("R6", 1, 0, 1, 4, 0, 0, 0, 0, 0);
        chk("R6", "no operand check", longint'(o_ld), 8);

        // R10: clear together with a load wins; the next use does not hit.
        cyc("R10", 1, 4, 0, 0, 0, 0, 2, 0, 1);
        chk("R10", "cleared", longint'(o_ld), 0);
        cyc("R10", 1, 0, 1, 2, 1, 2, 0, 0, 0);
        chk("R10", "mark removed", longint'(o_ld), 0);

        // R7 / R8: random stream from a small register pool.
        for (int i = 0; i < 5000; i++) begin
            cyc("R8",
                ($urandom_range(0, 9) < 8),
                int'($urandom_range(0, 7)),
                $urandom_range(0, 1) == 1, int'($urandom_range(0, 3)),
                $urandom_range(0, 1) == 1, int'($urandom_range(0, 3)),
                int'($urandom_range(0, 3)),
                $urandom_range(0, 1) == 1,
                ($urandom_range(0, 999) == 0));
        end
        idle("R7");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule